// File: doc/BRIEF.md
# Bitmap-Encoded Trie Search Stage

This block performs one step of a longest-prefix-match walk through a multibit trie whose nodes are stored in compressed bitmap form. A caller presents a node address, the four key bits that this node consumes, and the best next-hop pointer found so far. The stage fetches the node word from an external synchronous single-port memory. It finds the deepest valid prefix along the key's path inside the node and, if one exists, replaces the best-match pointer. It also works out where the next child node lives, or reports that the walk ends here.

A node keeps no explicit pointers per entry. Every prefix position inside the node is one bit of a breadth-first prefix vector, and every possible child is one bit of a child vector. A next-hop address is the next-hop base plus the number of set prefix bits below the matching position. A child address is the child base plus the number of set child bits below the key's position.

Control is a four-state machine. **IDLE** waits for `start`. The transition IDLE→READ fires on `start` and issues the memory read in that same cycle. READ→EVAL is unconditional; READ captures the returned node word. EVAL→DONE is unconditional; EVAL computes the results and registers them. DONE→IDLE is unconditional; DONE raises `done` for one cycle. In every state except IDLE, `start` is ignored.

Top module: `trie_stage`

## Requirements
- R1: While reset is asserted and until the first result, `done`, `mem_rd_en`, `best_out`, `child_addr` and `no_child` are all zero.
- R2: `mem_rd_en` is high only in a cycle where the machine is idle and `start` is high. In that cycle `mem_addr` equals `node_addr`. The memory returns the word on the clock edge after the read. The word's layout, from bit 0 upward, is: child vector (16 bits), prefix vector (15 bits), child base (ADDR_W bits), next-hop base (NH_W bits).
- R3: `done` is high for exactly one cycle. That cycle is the third cycle after the cycle in which the read was issued.
- R4: Prefix vector bit (2^L − 1) + v stands for the prefix of length L (0 to 3) whose value is v. Here v is the top L bits of the key. Bit 0 is the empty prefix, bits 1 and 2 are 0* and 1*, and bit 14 is 111*.
- R5: If any prefix bit on the key's path is set, the deepest one wins. `best_out` then equals the next-hop base plus the count of set prefix bits at indices below the winning index.
- R6: If no prefix bit on the key's path is set, `best_out` equals the `best_in` captured with the accepted `start`.
- R7: If child vector bit `key` is set, `no_child` is 0 and `child_addr` equals the child base plus the count of set child bits below position `key`.
- R8: If child vector bit `key` is clear, `no_child` is 1 and `child_addr` is 0.
- R9: A `start` that arrives while a search is in progress issues no read and does not change the result of that search.
- R10: `best_out`, `child_addr` and `no_child` change only at the edge that starts a `done` cycle. They hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search step (accepted only when idle) |
| node_addr | input | ADDR_W | Address of the node word to fetch |
| key | input | STRIDE | Key bits consumed by this node |
| best_in | input | NH_W | Best next-hop pointer found so far |
| mem_rd_en | output | 1 | Node memory read strobe |
| mem_addr | output | ADDR_W | Node memory address |
| mem_rdata | input | 2^STRIDE−1+2^STRIDE+ADDR_W+NH_W | Node word, valid one cycle after the read |
| done | output | 1 | Results are valid this cycle |
| best_out | output | NH_W | Updated best next-hop pointer |
| child_addr | output | ADDR_W | Address of the next child node |
| no_child | output | 1 | The walk ends at this node |

## Verification
The bench sweeps all sixteen key values over a set of crafted nodes:
- a node with only the empty prefix;
- a node with no prefixes at all;
- a node with every bit set;
- a node whose deepest match sits at the last row;
- many pseudo-random nodes.

A design that picked the shallowest match, or that counted the set bit at the matching position itself, returns a next-hop address off by one or more. A design that dropped the pass-through path clobbers `best_in` with a bogus address. A design that ranked children inclusively, or left `child_addr` nonzero on a missing child, is caught by comparing exact addresses on every `done`.

Back-to-back starts held high through whole searches expose a machine that accepts a new request while busy. The same starts also expose one that re-reads memory, or that shifts the one-cycle `done` pulse.

// File: rtl/trie_pkg.sv
package trie_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EVAL = 2'd2,
        ST_DONE = 2'd3
    } stage_state_t;

endpackage

// File: rtl/trie_rank.sv
// Counts the set bits of a vector strictly below a given position.
module trie_rank #(
    parameter int W  = 16,
    parameter int PW = $clog2(W),
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    input  logic [PW-1:0] pos,
    output logic [CW-1:0] cnt
);

    logic [W-1:0] below;

    for (genvar i = 0; i < W; i++) begin : g_mask
        assign below[i] = vec[i] & (PW'(i) < pos);
    end

    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(below[i]);
        end
    end

endmodule

// File: rtl/trie_path_select.sv
// Finds the deepest set prefix bit along the key's path through a node.
module trie_path_select #(
    parameter int STRIDE = 4,
    parameter int PFX_W  = (2 ** STRIDE) - 1,
    parameter int PIDX_W = $clog2(PFX_W)
) (
    input  logic [STRIDE-1:0] key,
    input  logic [PFX_W-1:0]  pfx_vec,
    output logic              hit,
    output logic [PIDX_W-1:0] idx
);

    logic [PIDX_W-1:0] lvl_idx [STRIDE];
    logic [STRIDE-1:0] lvl_hit;

    // Level L holds 2^L prefixes starting at index 2^L - 1 (breadth-first).
    for (genvar l = 0; l < STRIDE; l++) begin : g_level
        localparam int BASE = (1 << l) - 1;
        assign lvl_idx[l] = PIDX_W'(BASE) + PIDX_W'(key >> (STRIDE - l));
        assign lvl_hit[l] = pfx_vec[lvl_idx[l]];
    end

    // Deeper levels overwrite shallower ones: longest match wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int l = 0; l < STRIDE; l++) begin
            if (lvl_hit[l]) begin
                hit = 1'b1;
                idx = lvl_idx[l];
            end
        end
    end

endmodule

// File: rtl/trie_stage.sv
module trie_stage
    import trie_pkg::*;
#(
    parameter int STRIDE = 4,
    parameter int ADDR_W = 10,
    parameter int NH_W   = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    node_addr,
    input  logic [STRIDE-1:0]    key,
    input  logic [NH_W-1:0]      best_in,
    output logic                 mem_rd_en,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [(2**STRIDE-1)+(2**STRIDE)+ADDR_W+NH_W-1:0] mem_rdata,
    output logic                 done,
    output logic [NH_W-1:0]      best_out,
    output logic [ADDR_W-1:0]    child_addr,
    output logic                 no_child
);

    localparam int PFX_W   = (2 ** STRIDE) - 1;
    localparam int CHD_W   = 2 ** STRIDE;
    localparam int NODE_W  = PFX_W + CHD_W + ADDR_W + NH_W;
    localparam int PIDX_W  = $clog2(PFX_W);
    localparam int PRANK_W = $clog2(PFX_W + 1);
    localparam int CRANK_W = $clog2(CHD_W + 1);
    localparam int PFX_LO  = CHD_W;
    localparam int CB_LO   = CHD_W + PFX_W;
    localparam int NB_LO   = CHD_W + PFX_W + ADDR_W;

    stage_state_t state_q, state_d;

    logic [STRIDE-1:0] key_q;
    logic [NH_W-1:0]   best_q;
    logic [NODE_W-1:0] node_q;

    logic [CHD_W-1:0]  chd_vec;
    logic [PFX_W-1:0]  pfx_vec;
    logic [ADDR_W-1:0] chd_base;
    logic [NH_W-1:0]   nh_base;

    logic              pfx_hit;
    logic [PIDX_W-1:0] pfx_idx;
    logic [PRANK_W-1:0] pfx_rank;
    logic [CRANK_W-1:0] chd_rank;
    logic              chd_present;
    logic              accept;

    assign chd_vec  = node_q[CHD_W-1:0];
    assign pfx_vec  = node_q[PFX_LO +: PFX_W];
    assign chd_base = node_q[CB_LO +: ADDR_W];
    assign nh_base  = node_q[NB_LO +: NH_W];

    trie_path_select #(.STRIDE(STRIDE)) path_i (
        .key     (key_q),
        .pfx_vec (pfx_vec),
        .hit     (pfx_hit),
        .idx     (pfx_idx)
    );

    trie_rank #(.W(PFX_W)) pfx_rank_i (
        .vec (pfx_vec),
        .pos (pfx_idx),
        .cnt (pfx_rank)
    );

    trie_rank #(.W(CHD_W)) chd_rank_i (
        .vec (chd_vec),
        .pos (key_q),
        .cnt (chd_rank)
    );

    assign chd_present = chd_vec[key_q];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_READ;
            ST_READ: state_d = ST_EVAL;
            ST_EVAL: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        accept    = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = start;
            ST_READ: ;
            ST_EVAL: ;
            ST_DONE: done = 1'b1;
        endcase
        mem_rd_en = accept;
        mem_addr  = node_addr;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q      <= '0;
            best_q     <= '0;
            node_q     <= '0;
            best_out   <= '0;
            child_addr <= '0;
            no_child   <= 1'b0;
        end else begin
            if (accept) begin
                key_q  <= key;
                best_q <= best_in;
            end
            if (state_q == ST_READ) begin
                node_q <= mem_rdata;
            end
            if (state_q == ST_EVAL) begin
                best_out   <= pfx_hit ? (nh_base + NH_W'(pfx_rank)) : best_q;
                child_addr <= chd_present ? (chd_base + ADDR_W'(chd_rank)) : '0;
                no_child   <= ~chd_present;
            end
        end
    end

endmodule

// File: rtl/trie_stage_chk.sv
module trie_stage_chk #(
    parameter int ADDR_W = 10,
    parameter int NH_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_rd_en,
    input logic              done,
    input logic [NH_W-1:0]   best_out,
    input logic [ADDR_W-1:0] child_addr,
    input logic              no_child
);

    logic [1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)              busy_cnt <= 2'd0;
        else if (mem_rd_en)      busy_cnt <= 2'd3;
        else if (busy_cnt != 0)  busy_cnt <= busy_cnt - 2'd1;
    end

    // R2
    rd_only_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> start);

    // R9
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (busy_cnt == 2'd0));

    // R3
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done == (busy_cnt == 2'd1));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    absent_child_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_child) |-> (child_addr == '0));

    // R10
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(best_out) && $stable(child_addr) && $stable(no_child)));

endmodule

bind trie_stage trie_stage_chk #(.ADDR_W(ADDR_W), .NH_W(NH_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_rd_en  (mem_rd_en),
    .done       (done),
    .best_out   (best_out),
    .child_addr (child_addr),
    .no_child   (no_child)
);

// File: tb/trie_stage_tb_top.sv
module trie_stage_tb_top;

    localparam int PERIOD = 10;
    localparam int STRIDE = 4;
    localparam int ADDR_W = 10;
    localparam int NH_W   = 12;
    localparam int NODE_W = 15 + 16 + ADDR_W + NH_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] node_addr = '0;
    logic [STRIDE-1:0] key = '0;
    logic [NH_W-1:0]   best_in = '0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [NODE_W-1:0] mem_rdata = '0;
    logic              done;
    logic [NH_W-1:0]   best_out;
    logic [ADDR_W-1:0] child_addr;
    logic              no_child;

    int errors = 0;
    int checks = 0;

    logic [NODE_W-1:0] mem [0:63];

    always #(PERIOD/2) clk = ~clk;

    trie_stage #(.STRIDE(STRIDE), .ADDR_W(ADDR_W), .NH_W(NH_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .node_addr(node_addr),
        .key(key), .best_in(best_in), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .best_out(best_out),
        .child_addr(child_addr), .no_child(no_child)
    );

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[5:0]];

    function automatic logic [NODE_W-1:0] mk_node(input logic [14:0] pfx, input logic [15:0] chd,
                                                   input logic [ADDR_W-1:0] cb, input logic [NH_W-1:0] nb);
        return {nb, cb, pfx, chd};
    endfunction

    // Behavioural reference of one search step
    task automatic ref_eval(input logic [NODE_W-1:0] w, input logic [3:0] k, input logic [NH_W-1:0] bin,
                            output logic [NH_W-1:0] b, output logic [ADDR_W-1:0] c,
                            output logic nc, output logic h);
        logic [15:0] chd;
        logic [14:0] pfx;
        int win, n;
        chd = w[15:0];
        pfx = w[30:16];
        win = -1;
        for (int len = 0; len < 4; len++) begin
            int pos;
            pos = (2 ** len) - 1 + (int'(k) / (2 ** (4 - len)));
            if (pfx[pos]) win = pos;
        end
        h = (win >= 0);
        if (h) begin
            n = 0;
            for (int i = 0; i < win; i++) n += int'(pfx[i]);
            b = w[NODE_W-1 -: NH_W] + NH_W'(n);
        end else b = bin;
        nc = !chd[k];
        if (nc) c = '0;
        else begin
            n = 0;
            for (int i = 0; i < int'(k); i++) n += int'(chd[i]);
            c = w[31 +: ADDR_W] + ADDR_W'(n);
        end
    endtask

    // Reference model state
    int                cnt = 0;
    logic [NH_W-1:0]   pend_b = '0, exp_b = '0;
    logic [ADDR_W-1:0] pend_c = '0, exp_c = '0;
    logic              pend_nc = 1'b0, exp_nc = 1'b0, pend_h = 1'b0, exp_h = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) cnt = 0;
        else if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 1) begin
                exp_b = pend_b; exp_c = pend_c; exp_nc = pend_nc; exp_h = pend_h;
            end
        end else if (start) begin
            ref_eval(mem[node_addr[5:0]], key, best_in, pend_b, pend_c, pend_nc, pend_h);
            cnt = 3;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every clock (negedge sample, inputs move at negedge+1)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(mem_rd_en == (cnt == 0 && start), "R2 R9 read strobe", int'(mem_rd_en), int'(cnt == 0 && start));
            if (mem_rd_en) chk(mem_addr == node_addr, "R2 address", int'(mem_addr), int'(node_addr));
            chk(done == (cnt == 1), "R3 done timing", int'(done), int'(cnt == 1));
            if (done) begin
                chk(best_out == exp_b, exp_h ? "R4 R5 best match" : "R6 pass-through", int'(best_out), int'(exp_b));
                chk(no_child == exp_nc, exp_nc ? "R8 no child flag" : "R7 child flag", int'(no_child), int'(exp_nc));
                chk(child_addr == exp_c, exp_nc ? "R8 child zero" : "R7 child address", int'(child_addr), int'(exp_c));
            end else begin
                chk(best_out == exp_b && child_addr == exp_c && no_child == exp_nc, "R10 outputs hold",
                    int'(best_out), int'(exp_b));
            end
        end
    end

    task automatic search(input int a, input logic [3:0] k, input logic [NH_W-1:0] b);
        @(negedge clk); #1;
        start = 1'b1; node_addr = ADDR_W'(a); key = k; best_in = b;
        @(negedge clk); #1;
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] s;
        s = 32'h1234_5679;
        mem[0] = mk_node(15'h0001, 16'h0000, 10'd100, 12'd200);       // only empty prefix
        mem[1] = mk_node(15'h1025, 16'hA5A5, 10'd300, 12'd400);       // *, 1*, 10*, 101*
        mem[2] = mk_node(15'h0000, 16'h0000, 10'd5,   12'd6);         // nothing
        mem[3] = mk_node(15'h7FFF, 16'hFFFF, 10'd1000, 12'd4000);     // all set
        for (int i = 4; i < 64; i++) begin
            logic [NODE_W-1:0] w;
            for (int j = 0; j < 2; j++) begin
                s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
                w = {w[NODE_W-33:0], s};
            end
            mem[i] = w;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(done == 0 && mem_rd_en == 0, "R1 reset strobes", int'(done), 0);
        chk(best_out == 0 && child_addr == 0 && no_child == 0, "R1 reset outputs", int'(best_out), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(best_out == 0 && child_addr == 0 && no_child == 0 && done == 0, "R1 after reset", int'(best_out), 0);

        // R4 R5 R6 R7 R8: every key over crafted nodes
        for (int n = 0; n < 4; n++)
            for (int k = 0; k < 16; k++)
                search(n, 4'(k), NH_W'(12'h0A0 + k));

        // Pseudo-random nodes
        for (int n = 4; n < 64; n++)
            for (int k = 0; k < 16; k += 5)
                search(n, 4'(k + n), NH_W'(n * 7));

        // R9: start held high across whole searches with changing inputs
        @(negedge clk); #1;
        start = 1'b1;
        for (int i = 0; i < 24; i++) begin
            node_addr = ADDR_W'(i % 8); key = 4'(i * 3); best_in = NH_W'(i + 50);
            @(negedge clk); #1;
        end
        start = 1'b0;
        repeat (5) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule